// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one read or write command into the column addresses of a whole DDR data burst. A load-mode command programs a small mode register, which sets the burst length (2, 4 or 8 beats), the burst ordering (sequential or interleaved) and the CAS latency code. A command start then captures a starting column. For each beat, the block presents one column address. The beat-advance strobe steps the sequence forward.

Every beat of a burst stays inside an aligned block whose size is the burst length. Only the low offset bits within that block change from beat to beat. In sequential order the offset counts up from the start offset and wraps inside the block. In interleaved order each offset is the start offset XOR the beat index.

The block checks the mode encodings. A load with a reserved operating mode is dropped. A command issued while the stored burst length or CAS latency is reserved is refused and raises a one-cycle error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid_o, last_beat_o and cmd_err_o are 0, and cas_code_o is 2'b00. The mode register resets to all zeros, which is a reserved burst length.
- R2: A load writes the mode register only when mode_ba_i is 2'b00 and mode_addr_i[12:7] is 6'b000000 (normal) or 6'b000010 (normal with DLL reset). Any other bank or operating-mode value leaves the register unchanged.
- R3: Burst length comes from mode_addr_i[2:0]: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. All other codes are reserved.
- R4: cas_code_o decodes mode_addr_i[6:4] as stored: 3'b010 gives 2'b01 (latency 2), 3'b110 gives 2'b10 (latency 2.5), and every other code gives 2'b00 (reserved).
- R5: With mode_addr_i[3]=0 (sequential), beat i has in-block offset (start + i) mod L, where L is the burst length and start is the low log2(L) bits of cmd_col_i.
- R6: With mode_addr_i[3]=1 (interleaved), beat i has in-block offset start XOR i.
- R7: Column bits above the in-block offset equal those of cmd_col_i for every beat of the burst.
- R8: An accepted command shows beat 0 with beat_valid_o=1 in the cycle after cmd_start_i. Each cycle with beat_advance high moves to the next beat. A cycle without it holds col_o.
- R9: last_beat_o is 1 exactly on the final beat. Advancing from that beat drops beat_valid_o in the next cycle.
- R10: cmd_start_i is ignored while beat_valid_o is 1.
- R11: A command issued while the stored burst length or CAS latency is reserved produces no beat. It raises cmd_err_o for exactly the next cycle.
- R12: A mode load during a burst does not change the length or ordering of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_load_i | input | 1 | Load-mode command strobe |
| mode_ba_i | input | 2 | Bank select for the load; 00 selects the base register |
| mode_addr_i | input | 13 | Mode value |
| cmd_start_i | input | 1 | Read/write command start strobe |
| cmd_col_i | input | COL_W | Starting column address |
| beat_adv_i | input | 1 | Advance to the next beat |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| last_beat_o | output | 1 | The current beat is the final beat of the burst |
| cas_code_o | output | 2 | Decoded CAS latency: 00 reserved, 01 is 2, 10 is 2.5 |
| cmd_err_o | output | 1 | One-cycle pulse when a command is refused |

## Verification
The assertions check, on every cycle, that:
- the mode register holds its value unless a load is valid;
- the last-beat flag appears only together with a valid beat;
- a stalled beat keeps its column;
- the upper column bits stay fixed during a burst;
- an error pulse never coincides with a beat.

Only the bench scenarios can show that the orderings are correct for particular starts and lengths. The scenarios also show that reserved codes and foreign bank values are dropped, and that a mode load in the middle of a burst leaves that burst unaltered. For these, the bench compares full column sequences with values it computes itself.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFF_W = 3;

  localparam logic [2:0] BL_2 = 3'b001;
  localparam logic [2:0] BL_4 = 3'b010;
  localparam logic [2:0] BL_8 = 3'b011;
  localparam logic [2:0] CL_2 = 3'b010;
  localparam logic [2:0] CL_25 = 3'b110;

  typedef enum logic [1:0] {
    CAS_NONE = 2'b00,
    CAS_2    = 2'b01,
    CAS_2P5  = 2'b10
  } cas_code_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
  } mode_fields_t;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OFF_W-1:0]  len_mask_o,
  output logic              bt_o,
  output logic              bl_ok_o,
  output logic              cl_ok_o,
  output cas_code_e         cas_code_o
);
  localparam int OP_LSB = 7;
  localparam int OP_W   = ADDR_W - OP_LSB;
  localparam logic [OP_W-1:0] OP_DLL = OP_W'(2);

  mode_fields_t mode_q;
  logic         op_ok, wr_en;

  assign op_ok = (addr_i[ADDR_W-1:OP_LSB] == '0) || (addr_i[ADDR_W-1:OP_LSB] == OP_DLL);
  assign wr_en = load_i && (ba_i == '0) && op_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (wr_en) mode_q <= '{bl: addr_i[2:0], bt: addr_i[3], cl: addr_i[6:4]};
  end

  always_comb begin
    unique case (mode_q.bl)
      BL_2:    len_mask_o = 3'b001;
      BL_4:    len_mask_o = 3'b011;
      BL_8:    len_mask_o = 3'b111;
      default: len_mask_o = 3'b000;
    endcase
    unique case (mode_q.cl)
      CL_2:    cas_code_o = CAS_2;
      CL_25:   cas_code_o = CAS_2P5;
      default: cas_code_o = CAS_NONE;
    endcase
  end

  assign bt_o    = mode_q.bt;
  assign bl_ok_o = len_mask_o != '0;
  assign cl_ok_o = cas_code_o != CAS_NONE;

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && (ba_i == '0) && op_ok) |=> $stable(mode_q));
endmodule

// File: rtl/bcs_burst_ctrl.sv
module bcs_burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_start_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic             beat_adv_i,
  input  logic [OFF_W-1:0] len_mask_i,
  input  logic             bt_i,
  input  logic             bl_ok_i,
  input  logic             cl_ok_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             err_o,
  output logic [COL_W-1:0] base_o,
  output logic [OFF_W-1:0] off_o,
  output logic [OFF_W-1:0] mask_o
);
  logic [OFF_W-1:0] idx_q, start_q, mask_q;
  logic             bt_q, busy_q, err_q;
  logic [COL_W-1:0] base_q;
  logic             accept, refuse;

  assign accept = cmd_start_i && !busy_q && bl_ok_i && cl_ok_i;
  assign refuse = cmd_start_i && !busy_q && !(bl_ok_i && cl_ok_i);
  assign last_o = busy_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      start_q <= '0;
      mask_q  <= '0;
      bt_q    <= 1'b0;
      base_q  <= '0;
    end else begin
      err_q <= refuse;
      if (accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        start_q <= cmd_col_i[OFF_W-1:0] & len_mask_i;
        mask_q  <= len_mask_i;
        bt_q    <= bt_i;
        base_q  <= cmd_col_i;
      end else if (busy_q && beat_adv_i) begin
        if (last_o) busy_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // sequential wraps through the mask; interleaved flips start bits
  assign off_o  = (bt_q ? (start_q ^ idx_q) : (start_q + idx_q)) & mask_q;
  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign base_o = base_q;
  assign mask_o = mask_q;

  // R9
  last_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && beat_adv_i |=> !busy_o);
  // R11
  err_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !beat_adv_i |=> busy_o && $stable(base_o));
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < OFF_W) begin : g_low
      assign col_o[b] = mask_i[b] ? off_i[b] : base_i[b];
    end else begin : g_high
      assign col_o[b] = base_i[b];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [BA_W-1:0]   mode_ba_i,
  input  logic [ADDR_W-1:0] mode_addr_i,
  input  logic              cmd_start_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic              beat_adv_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              last_beat_o,
  output logic [1:0]        cas_code_o,
  output logic              cmd_err_o
);
  logic [OFF_W-1:0] len_mask, off, act_mask;
  logic             bt, bl_ok, cl_ok;
  logic [COL_W-1:0] base;
  cas_code_e        cas;

  bcs_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk_i, .rst_ni,
    .load_i(mode_load_i), .ba_i(mode_ba_i), .addr_i(mode_addr_i),
    .len_mask_o(len_mask), .bt_o(bt), .bl_ok_o(bl_ok), .cl_ok_o(cl_ok),
    .cas_code_o(cas)
  );

  bcs_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_start_i, .cmd_col_i, .beat_adv_i,
    .len_mask_i(len_mask), .bt_i(bt), .bl_ok_i(bl_ok), .cl_ok_i(cl_ok),
    .busy_o(beat_valid_o), .last_o(last_beat_o), .err_o(cmd_err_o),
    .base_o(base), .off_o(off), .mask_o(act_mask)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_col (
    .base_i(base), .off_i(off), .mask_i(act_mask), .col_o(col_o)
  );

  assign cas_code_o = cas;

  // R9
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat_o |-> beat_valid_o);
  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_adv_i |=> beat_valid_o && $stable(col_o));
  // R7
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_adv_i && !last_beat_o |=>
      col_o[COL_W-1:OFF_W] == $past(col_o[COL_W-1:OFF_W]));
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W = 10;

  logic             clk = 0, rst_n = 0;
  logic             mode_load = 0, cmd_start = 0, beat_adv = 0;
  logic [1:0]       mode_ba = 0;
  logic [12:0]      mode_addr = 0;
  logic [COL_W-1:0] cmd_col = 0;
  logic [COL_W-1:0] col;
  logic             beat_valid, last_beat, cmd_err;
  logic [1:0]       cas_code;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_load_i(mode_load), .mode_ba_i(mode_ba), .mode_addr_i(mode_addr),
    .cmd_start_i(cmd_start), .cmd_col_i(cmd_col), .beat_adv_i(beat_adv),
    .col_o(col), .beat_valid_o(beat_valid), .last_beat_o(last_beat),
    .cas_code_o(cas_code), .cmd_err_o(cmd_err)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk_mode(logic [5:0] op, logic [2:0] cl, logic bt, logic [2:0] bl);
    return {op, cl, bt, bl};
  endfunction

  task automatic load_mode(logic [1:0] ba, logic [12:0] val);
    @(negedge clk);
    mode_load = 1; mode_ba = ba; mode_addr = val;
    @(negedge clk);
    mode_load = 0; mode_ba = 0;
  endtask

  // expected in-block offset per requirement
  function automatic int exp_col(int start_col, int len, bit il, int i);
    int s = start_col % len;
    int o = il ? (s ^ i) : ((s + i) % len);
    return (start_col - s) + o;
  endfunction

  task automatic run_burst(string req, int start_col, int len, bit il, int stall_at);
    @(negedge clk);
    cmd_start = 1; cmd_col = COL_W'(start_col);
    @(negedge clk);
    cmd_start = 0;
    for (int i = 0; i < len; i++) begin
      check({req, " valid"}, beat_valid, 1);
      check({req, " col"}, col, exp_col(start_col, len, il, i));
      check({req, " last"}, last_beat, (i == len - 1));
      if (i == stall_at) begin
        @(negedge clk);
        check("R8 stall hold", col, exp_col(start_col, len, il, i));
      end
      beat_adv = 1;
      @(negedge clk);
      beat_adv = 0;
    end
    check({req, " end"}, beat_valid, 0);
  endtask

  task automatic expect_refuse(string req, int start_col);
    @(negedge clk);
    cmd_start = 1; cmd_col = COL_W'(start_col);
    @(negedge clk);
    cmd_start = 0;
    check({req, " err"}, cmd_err, 1);
    check({req, " no beat"}, beat_valid, 0);
    @(negedge clk);
    check({req, " err once"}, cmd_err, 0);
    check({req, " still idle"}, beat_valid, 0);
  endtask

  task automatic t_reset;
    check("R1 valid", beat_valid, 0);
    check("R1 last", last_beat, 0);
    check("R1 err", cmd_err, 0);
    check("R1 cas", cas_code, 0);
    expect_refuse("R1 R11 unprogrammed", 'h010);
  endtask

  task automatic t_seq4;
    load_mode(2'b00, mk_mode(6'd0, 3'b010, 1'b0, 3'b010));
    check("R4 cas2", cas_code, 1);
    run_burst("R5 R7 seq4", 'h1A1, 4, 0, -1);
  endtask

  task automatic t_il8;
    load_mode(2'b00, mk_mode(6'd0, 3'b110, 1'b1, 3'b011));
    check("R4 cas2.5", cas_code, 2);
    run_burst("R6 R7 il8", 'h2C5, 8, 1, 3);
  endtask

  task automatic t_seq2_seq8;
    load_mode(2'b00, mk_mode(6'b000010, 3'b010, 1'b0, 3'b001));
    check("R2 dll load cas", cas_code, 1);
    run_burst("R3 R5 seq2", 'h0F3, 2, 0, 0);
    load_mode(2'b00, mk_mode(6'd0, 3'b010, 1'b0, 3'b011));
    run_burst("R3 R5 seq8", 'h3FE, 8, 0, -1);
  endtask

  task automatic t_ignored_loads;
    load_mode(2'b01, mk_mode(6'd0, 3'b110, 1'b1, 3'b001));
    check("R2 ext bank cas", cas_code, 1);
    load_mode(2'b00, mk_mode(6'b100000, 3'b110, 1'b1, 3'b001));
    check("R2 reserved op cas", cas_code, 1);
    run_burst("R2 unchanged seq8", 'h105, 8, 0, -1);
  endtask

  task automatic t_reserved;
    load_mode(2'b00, mk_mode(6'd0, 3'b010, 1'b0, 3'b100));
    expect_refuse("R3 R11 reserved len", 'h020);
    load_mode(2'b00, mk_mode(6'd0, 3'b011, 1'b0, 3'b010));
    check("R4 reserved cas", cas_code, 0);
    expect_refuse("R11 reserved cas", 'h021);
  endtask

  task automatic t_busy_and_midload;
    load_mode(2'b00, mk_mode(6'd0, 3'b010, 1'b1, 3'b010));
    @(negedge clk);
    cmd_start = 1; cmd_col = 'h042;
    @(negedge clk);
    cmd_start = 1; cmd_col = 'h3F0;
    mode_load = 1; mode_addr = mk_mode(6'd0, 3'b010, 1'b0, 3'b001);
    @(negedge clk);
    cmd_start = 0; mode_load = 0;
    for (int i = 0; i < 4; i++) begin
      check("R10 R12 valid", beat_valid, 1);
      check("R10 R12 col", col, 'h040 + (2 ^ i));
      check("R12 last", last_beat, (i == 3));
      beat_adv = 1;
      @(negedge clk);
      beat_adv = 0;
    end
    check("R9 R10 end", beat_valid, 0);
    run_burst("R12 new mode seq2", 'h0A0, 2, 0, -1);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seq4();
    t_il8();
    t_seq2_seq8();
    t_ignored_loads();
    t_reserved();
    t_busy_and_midload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule